// File: doc/BRIEF.md
# Transmit Driver Activity Monitor

This block supervises an eight-channel line transmitter and flags any channel whose driver has gone quiet. Each channel supplies two digital pulse-detect strobes, one per output rail. A per-channel counter tracks the transmit clock cycles since the last strobe on either rail. Once a channel has been silent for longer than a set limit, its failure pin goes high. The pin stays high until a fresh pulse is seen on that channel.

The failure state of every channel is also visible through a small host register port. The host can enable a per-channel interrupt. Any change of a channel's failure status, in either direction, then latches a sticky pending bit. The OR of the pending bits drives a single active-high interrupt line. Reading the pending register clears the bits that the read returned. The failure pins work whatever the host does, so a board that does not use the register port still gets the pin indications.

Top module: `txdrv_activity_mon`

## Requirements
- R1: After a pulse on a channel, that channel's `drv_fail` bit stays 0 through the next LIMIT (default 128) pulse-free clock edges. It goes to 1 on the edge that makes the silent run longer than LIMIT (the 129th).
- R2: A pulse on either rail of a channel, sampled at a clock edge, clears that channel's `drv_fail` bit at the same edge. The silent count restarts from zero, so another LIMIT+1 silent edges are needed before the bit fails again.
- R3: While a channel stays silent, its `drv_fail` bit stays 1 for any length of time. The counter saturates and never wraps.
- R4: Channels are independent: pulses or silence on one channel never change the failure bit, or the failure timing, of another.
- R5: A read at address 0 (status) returns the failure bits, bit i for channel i, on `host_rdata` after the clock edge that sampled `host_rd`.
- R6: Address 1 is the interrupt-enable register: it is read and written with bit i for channel i. Writes to any other address change no register.
- R7: A rise or a fall of channel i's failure bit sets pending bit i on the same edge, but only if enable bit i is 1. No pending bit is set while its enable bit is 0.
- R8: A read at address 2 returns the pending bits and clears exactly the bits it returned. A status transition on the same edge still sets its pending bit.
- R9: `irq` is high exactly when at least one pending bit is set. It changes on the same edge as the pending bits.
- R10: A synchronous active-high `rst` clears all counters, failure bits, enable bits and pending bits, and deasserts `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pos_det | input | NCH | Positive-rail pulse strobe, one bit per channel |
| tx_neg_det | input | NCH | Negative-rail pulse strobe, one bit per channel |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register address: 0 status, 1 enable, 2 pending |
| host_wdata | input | NCH | Host write data |
| host_rdata | output | NCH | Registered host read data |
| drv_fail | output | NCH | Per-channel driver failure indication |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench probes the exact edge of the timeout. It checks the failure bit at 128 silent edges and again at 129, so an off-by-one counter shows up as a failure one cycle early or late. It holds a channel silent for hundreds of cycles to catch a counter that wraps and drops the failure on its own. It also checks that a single strobe on the negative rail alone clears the failure, which a design that watches only one rail would miss. Finally, it times a new failure to land on the same edge as a pending-register read: a design that clears first and sets second would lose that interrupt. It also checks that a disabled channel never raises `irq`.

// File: rtl/dmon_pkg.sv
package dmon_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_PEND = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/dmon_chan.sv
module dmon_chan #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_p,
  input  logic pulse_n,
  output logic fail_q,
  output logic fail_n
);
  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (pulse_p || pulse_n)
      cnt_n = '0;
    else if (cnt_q > LIM)
      cnt_n = cnt_q;
    else
      cnt_n = cnt_q + 1'b1;
    fail_n = (cnt_n > LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      fail_q <= fail_n;
    end
  end
endmodule

// File: rtl/dmon_irq.sv
module dmon_irq #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] fail_q,
  input  logic [NCH-1:0] fail_n,
  input  logic [NCH-1:0] en_q,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend_q,
  output logic           irq_o
);
  logic [NCH-1:0] set_v, pend_n;

  always_comb begin
    set_v  = (fail_q ^ fail_n) & en_q;
    pend_n = (pend_q & ~clr) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      irq_o  <= |pend_n;
    end
  end
endmodule

// File: rtl/dmon_regs.sv
module dmon_regs
  import dmon_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wdata,
  input  logic [NCH-1:0]    fail_q,
  input  logic [NCH-1:0]    pend_q,
  output logic [NCH-1:0]    en_q,
  output logic [NCH-1:0]    clr,
  output logic [NCH-1:0]    rdata
);
  logic [NCH-1:0] rd_mux;

  always_comb begin
    unique case (addr)
      REG_STAT: rd_mux = fail_q;
      REG_EN:   rd_mux = en_q;
      REG_PEND: rd_mux = pend_q;
      default:  rd_mux = '0;
    endcase
    clr = (rd && addr == REG_PEND) ? pend_q : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      rdata <= '0;
    end else begin
      if (wr && addr == REG_EN) en_q <= wdata;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/txdrv_activity_mon.sv
module txdrv_activity_mon
  import dmon_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int LIMIT = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    tx_pos_det,
  input  logic [NCH-1:0]    tx_neg_det,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [NCH-1:0]    host_wdata,
  output logic [NCH-1:0]    host_rdata,
  output logic [NCH-1:0]    drv_fail,
  output logic              irq
);
  logic [NCH-1:0] fail_q, fail_n, en_q, pend_q, clr;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmon_chan #(.LIMIT(LIMIT)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .pulse_p(tx_pos_det[g]),
      .pulse_n(tx_neg_det[g]),
      .fail_q (fail_q[g]),
      .fail_n (fail_n[g])
    );
  end

  dmon_irq #(.NCH(NCH)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .fail_q(fail_q),
    .fail_n(fail_n),
    .en_q  (en_q),
    .clr   (clr),
    .pend_q(pend_q),
    .irq_o (irq)
  );

  dmon_regs #(.NCH(NCH)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (host_wr),
    .rd    (host_rd),
    .addr  (host_addr),
    .wdata (host_wdata),
    .fail_q(fail_q),
    .pend_q(pend_q),
    .en_q  (en_q),
    .clr   (clr),
    .rdata (host_rdata)
  );

  assign drv_fail = fail_q;
endmodule

// File: rtl/dmon_chk.sv
module dmon_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] pos,
  input logic [NCH-1:0] neg,
  input logic [NCH-1:0] fail,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] pend,
  input logic           irq
);
  // R2
  pulse_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pos | neg)) |=> ((fail & $past(pos | neg)) == '0));

  // R3
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|(fail & ~(pos | neg))) |=> (($past(fail) & ~$past(pos | neg) & ~fail) == '0));

  // R7
  edge_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (|(($past(fail) ^ fail) & $past(en))) |-> irq);

  // R7
  no_pend_without_en_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(en)) == '0));

  // R9
  irq_matches_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (pend != '0));

  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fail == '0 && en == '0 && pend == '0 && !irq));
endmodule

bind txdrv_activity_mon dmon_chk #(.NCH(NCH)) u_chk (
  .clk (clk),
  .rst (rst),
  .pos (tx_pos_det),
  .neg (tx_neg_det),
  .fail(drv_fail),
  .en  (en_q),
  .pend(pend_q),
  .irq (irq)
);

// File: tb/txdrv_activity_mon_bench.sv
module txdrv_activity_mon_bench;
  localparam int NCH = 8;
  localparam int K_FAIL = 0, K_IRQ = 1, K_RDATA = 2;

  typedef struct {
    int         kind;
    logic [7:0] val;
    string      tag;
  } item_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] tx_pos_det = '0, tx_neg_det = '0;
  logic           host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]     host_addr = '0;
  logic [NCH-1:0] host_wdata = '0;
  logic [NCH-1:0] host_rdata, drv_fail;
  logic           irq;

  logic [NCH-1:0] keep = 8'hFF;
  logic [NCH-1:0] alt  = 8'h55;
  item_t          q[$];
  int             n_chk = 0, n_bad = 0;
  bit             done = 1'b0;

  always #5 clk = ~clk;

  txdrv_activity_mon #(.NCH(NCH), .LIMIT(128)) u_txdrv_activity_mon (
    .clk(clk), .rst(rst), .tx_pos_det(tx_pos_det), .tx_neg_det(tx_neg_det),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .drv_fail(drv_fail), .irq(irq)
  );

  task automatic step(input logic [7:0] pm, input logic [7:0] nm,
                      input bit wr, input bit rd, input logic [1:0] a, input logic [7:0] wd);
    @(negedge clk);
    tx_pos_det = (keep & alt) | pm;
    tx_neg_det = (keep & ~alt) | nm;
    alt        = ~alt;
    host_wr    = wr;
    host_rd    = rd;
    host_addr  = a;
    host_wdata = wd;
    @(posedge clk);
    #1;
    host_wr = 1'b0;
    host_rd = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) step('0, '0, 0, 0, 2'd0, '0);
  endtask

  task automatic rd(input logic [1:0] a);
    step('0, '0, 0, 1, a, '0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step('0, '0, 1, 0, a, d);
  endtask

  task automatic expect_it(input int kind, input logic [7:0] val, input string tag);
    item_t it;
    it.kind = kind;
    it.val  = val;
    it.tag  = tag;
    q.push_back(it);
    #0;
  endtask

  // Monitor: pops expected items and compares them with the design outputs.
  initial begin
    forever begin
      item_t it;
      logic [7:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      case (it.kind)
        K_FAIL:  act = drv_fail;
        K_IRQ:   act = {7'd0, irq};
        default: act = host_rdata;
      endcase
      n_chk++;
      if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    expect_it(K_FAIL, 8'h00, "R10 fail after reset");
    expect_it(K_IRQ, 8'h00, "R10 irq after reset");
    rd(2'd1); expect_it(K_RDATA, 8'h00, "R10 R6 enable after reset");
    rd(2'd2); expect_it(K_RDATA, 8'h00, "R10 pending after reset");

    wr(2'd1, 8'h03);
    rd(2'd1); expect_it(K_RDATA, 8'h03, "R6 enable readback");
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd1); expect_it(K_RDATA, 8'h03, "R6 other-address writes ignored");

    // R1: channel 0 silent from here; last pulse was at the previous edge
    keep = 8'hFE;
    cyc(128);
    expect_it(K_FAIL, 8'h00, "R1 no fail at 128 silent edges");
    expect_it(K_IRQ, 8'h00, "R1 no irq yet");
    cyc(1);
    expect_it(K_FAIL, 8'h01, "R1 fail at 129th silent edge");
    expect_it(K_IRQ, 8'h01, "R7 R9 irq on rise");

    rd(2'd0); expect_it(K_RDATA, 8'h01, "R5 status read");
    rd(2'd2); expect_it(K_RDATA, 8'h01, "R8 pending read");
    expect_it(K_IRQ, 8'h00, "R8 R9 irq cleared by read");
    rd(2'd2); expect_it(K_RDATA, 8'h00, "R8 pending empty");

    cyc(300);
    expect_it(K_FAIL, 8'h01, "R3 fail held while silent");
    expect_it(K_IRQ, 8'h00, "R3 no spurious irq");

    // R2: single negative-rail pulse clears channel 0
    step('0, 8'h01, 0, 0, 2'd0, '0);
    expect_it(K_FAIL, 8'h00, "R2 neg rail clears fail");
    expect_it(K_IRQ, 8'h01, "R7 irq on fall");
    rd(2'd2); expect_it(K_RDATA, 8'h01, "R7 pending on fall");
    cyc(127);
    expect_it(K_FAIL, 8'h00, "R2 count restarted");
    cyc(1);
    expect_it(K_FAIL, 8'h01, "R2 fail again after restart");
    rd(2'd2); expect_it(K_RDATA, 8'h01, "R7 pending on second rise");

    // R4: channels 0,1,2 silent, channel 2 restarted later, channel 2 disabled
    keep = 8'hF8;
    step(8'h07, '0, 0, 0, 2'd0, '0);
    cyc(50);
    step(8'h04, '0, 0, 0, 2'd0, '0);
    cyc(77);
    expect_it(K_FAIL, 8'h00, "R4 no channel failed yet");
    cyc(1);
    expect_it(K_FAIL, 8'h03, "R4 channels 0 and 1 fail together");
    cyc(50);
    expect_it(K_FAIL, 8'h03, "R4 channel 2 still alive");
    cyc(1);
    expect_it(K_FAIL, 8'h07, "R4 channel 2 fails later");
    rd(2'd2); expect_it(K_RDATA, 8'h03, "R7 disabled channel 2 not pending");
    expect_it(K_IRQ, 8'h00, "R9 irq low after clear");

    // R8: new event on the same edge as a pending read
    step(8'h01, '0, 0, 0, 2'd0, '0);
    expect_it(K_FAIL, 8'h06, "R2 pos rail clears channel 0");
    cyc(128);
    rd(2'd2); expect_it(K_RDATA, 8'h01, "R8 read returns old pending");
    expect_it(K_FAIL, 8'h07, "R1 channel 0 fails on read edge");
    expect_it(K_IRQ, 8'h01, "R8 same-edge event kept");
    rd(2'd2); expect_it(K_RDATA, 8'h01, "R8 kept bit readable");
    expect_it(K_IRQ, 8'h00, "R9 irq low again");

    // R7: with enables off, transitions set nothing
    wr(2'd1, 8'h00);
    step(8'h07, '0, 0, 0, 2'd0, '0);
    expect_it(K_FAIL, 8'h00, "R2 all channels cleared");
    expect_it(K_IRQ, 8'h00, "R7 no irq when disabled");
    rd(2'd2); expect_it(K_RDATA, 8'h00, "R7 nothing pending when disabled");

    #2;
    wait (q.size() == 0);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule